// File: doc/BRIEF.md
# Cache Victim Way Selector

This block chooses which way of a four-way set-associative cache is filled when a new line arrives. A linefill request is answered one clock later with a way index and a one-cycle valid strobe. Two allocation policies exist: a rotating pointer (round-robin) and a choice drawn from a free-running 16-bit linear feedback shift register (pseudo-random). A single control input picks the active policy at run time.

A per-way exclusion mask removes ways from allocation under both policies. Software uses it to pin contents in place, or to confine new lines to a few ways so that a streaming task cannot evict everything. When the cache is disabled the selector grants nothing.

The controller has three named states. `VS_OFF` means the cache is disabled and no grant is made. `VS_ROUND` is round-robin allocation and `VS_RANDOM` is pseudo-random allocation. The named transitions are: *enable*, from `VS_OFF` to the state that matches the policy input; *switch*, between `VS_ROUND` and `VS_RANDOM` when the policy input changes; and *disable*, from any state to `VS_OFF` when the enable input falls. Every transition takes effect at the next clock edge. Enable and switch both reset the rotation pointer.

Top module: `vws_victim_sel`

## Requirements
- R1: During and right after reset, `victim_valid` is 0 and `victim_way` is 0. The controller starts in `VS_OFF`.
- R2: While `cache_en` is 0, `victim_valid` stays 0 whatever `fill_req` does. A request made in a cycle where the controller is still in `VS_OFF` is not granted.
- R3: A request that is granted in cycle t produces `victim_valid`=1 and the chosen way in cycle t+1. Each granted request gives exactly one valid cycle. `victim_way` holds its last value while `victim_valid` is 0.
- R4: `policy_rand`=0 selects round-robin and `policy_rand`=1 selects pseudo-random. The controller state follows the input one clock later. A request made in the same cycle as a change is therefore served with the old policy.
- R5: Round-robin grants the first allowed way found by scanning upward from the pointer, wrapping from way 3 to way 0. The pointer then moves to the way after the granted one. The pointer moves only when a round-robin grant is made.
- R6: The enable and switch transitions reset the pointer to the lowest allowed way under the mask present at that edge. The first round-robin grant after such a transition is therefore the lowest allowed way.
- R7: The random source starts at 0xACE1 and steps at every clock after reset, in all states. Each step shifts left and feeds bit 0 with the XOR of bits 15, 13, 12 and 10. A pseudo-random request uses the value held before the grant edge, and its candidate way is bits [1:0] of that value.
- R8: If the pseudo-random candidate is excluded, the lowest allowed way is granted instead.
- R9: `lock_mask` bit i = 1 excludes way i under both policies. While at least one way is allowed, an excluded way is never granted.
- R10: If all four mask bits are 1, a granted request returns way 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cache_en | input | 1 | Cache enable; 0 forces the `VS_OFF` state |
| policy_rand | input | 1 | Policy select: 0 round-robin, 1 pseudo-random |
| fill_req | input | 1 | Linefill allocation request |
| lock_mask | input | 4 | Per-way exclusion mask; bit i = 1 excludes way i |
| victim_valid | output | 1 | One-cycle strobe marking a granted way |
| victim_way | output | 2 | Index of the granted way |

## Verification
Round-robin is driven under all sixteen mask values, with back-to-back requests and requests separated by idle gaps. This separates skipping excluded ways from plain rotation, and shows that the pointer stays still when no grant is made. Pseudo-random is swept over the same masks for many cycles. This tells a direct candidate grant apart from the lowest-allowed fallback and from the all-excluded case. Requests are also placed on the policy-change edge, right after re-enabling, and while disabled. These cases separate the one-cycle state lag, the pointer reset and the grant suppression from one another.

// File: rtl/vws_pkg.sv
package vws_pkg;
    typedef enum logic [1:0] {
        VS_OFF    = 2'd0,
        VS_ROUND  = 2'd1,
        VS_RANDOM = 2'd2
    } vws_state_e;
endpackage

// File: rtl/vws_lfsr.sv
module vws_lfsr #(
    parameter int               LFSR_W = 16,
    parameter logic [LFSR_W-1:0] TAPS  = 16'hB400,
    parameter logic [LFSR_W-1:0] SEED  = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [LFSR_W-1:0] value
);
    logic [LFSR_W-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SEED;
        else        q <= {q[LFSR_W-2:0], ^(q & TAPS)};
    end

    assign value = q;

    // R7: a nonzero seed never collapses to the all-zero lockup state
    a_r7_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        q != '0);
endmodule

// File: rtl/vws_way_scan.sv
module vws_way_scan #(
    parameter int NUM_WAYS = 4,
    parameter int IDX_W    = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS-1:0] allow,
    input  logic [IDX_W-1:0]    start,
    output logic [IDX_W-1:0]    from_start,
    output logic [IDX_W-1:0]    lowest,
    output logic                any_allowed
);
    always_comb begin
        lowest = '0;
        for (int i = NUM_WAYS - 1; i >= 0; i--) begin
            if (allow[i]) lowest = IDX_W'(i);
        end
    end

    always_comb begin
        int  idx;
        logic hit;
        from_start = '0;
        hit        = 1'b0;
        for (int k = 0; k < NUM_WAYS; k++) begin
            idx = (int'(start) + k) % NUM_WAYS;
            if (!hit && allow[idx]) begin
                from_start = IDX_W'(idx);
                hit        = 1'b1;
            end
        end
    end

    assign any_allowed = |allow;
endmodule

// File: rtl/vws_victim_sel.sv
module vws_victim_sel #(
    parameter int                NUM_WAYS = 4,
    parameter int                LFSR_W   = 16,
    parameter logic [LFSR_W-1:0] TAPS     = 16'hB400,
    parameter logic [LFSR_W-1:0] SEED     = 16'hACE1,
    localparam int               IDX_W    = $clog2(NUM_WAYS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cache_en,
    input  logic                policy_rand,
    input  logic                fill_req,
    input  logic [NUM_WAYS-1:0] lock_mask,
    output logic                victim_valid,
    output logic [IDX_W-1:0]    victim_way
);
    import vws_pkg::*;

    vws_state_e        state_q, state_d;
    logic [IDX_W-1:0]  ptr_q;
    logic [LFSR_W-1:0] rnd;
    logic [NUM_WAYS-1:0] allow;
    logic [IDX_W-1:0]  rr_pick, low_pick, cand, chosen;
    logic              any_ok, cand_ok, grant, rearm;

    assign allow = ~lock_mask;

    vws_lfsr #(.LFSR_W(LFSR_W), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .value (rnd)
    );

    vws_way_scan #(.NUM_WAYS(NUM_WAYS), .IDX_W(IDX_W)) u_scan (
        .allow       (allow),
        .start       (ptr_q),
        .from_start  (rr_pick),
        .lowest      (low_pick),
        .any_allowed (any_ok)
    );

    assign cand    = rnd[IDX_W-1:0];
    assign cand_ok = (int'(cand) < NUM_WAYS) && allow[cand];

    // next-state: enable, switch and disable transitions
    always_comb begin
        unique case (state_q)
            VS_OFF:    state_d = !cache_en ? VS_OFF : (policy_rand ? VS_RANDOM : VS_ROUND);
            VS_ROUND:  state_d = !cache_en ? VS_OFF : (policy_rand ? VS_RANDOM : VS_ROUND);
            VS_RANDOM: state_d = !cache_en ? VS_OFF : (policy_rand ? VS_RANDOM : VS_ROUND);
            default:   state_d = VS_OFF;
        endcase
    end

    assign grant = fill_req && cache_en && (state_q != VS_OFF);
    assign rearm = (state_d != state_q) && (state_d != VS_OFF);

    always_comb begin
        chosen = '0;
        unique case (state_q)
            VS_ROUND:  chosen = any_ok ? rr_pick : '0;
            VS_RANDOM: chosen = cand_ok ? cand : (any_ok ? low_pick : '0);
            default:   chosen = '0;
        endcase
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= VS_OFF;
        else        state_q <= state_d;
    end

    // rotation pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (rearm) begin
            ptr_q <= low_pick;
        end else if (grant && state_q == VS_ROUND) begin
            ptr_q <= (int'(chosen) == NUM_WAYS - 1) ? '0 : chosen + 1'b1;
        end
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            victim_valid <= 1'b0;
            victim_way   <= '0;
        end else begin
            victim_valid <= grant;
            if (grant) victim_way <= chosen;
        end
    end

    a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cache_en |=> !victim_valid);

    a_r3_valid_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> ($past(fill_req) && $past(cache_en)));

    a_r9_locked_never_chosen: assert property (@(posedge clk) disable iff (!rst_n)
        (victim_valid && $past(allow) != '0)
            |-> ((($past(lock_mask)) >> victim_way) & NUM_WAYS'(1)) == '0);

    a_r10_all_locked_way0: assert property (@(posedge clk) disable iff (!rst_n)
        (victim_valid && $past(allow) == '0) |-> victim_way == '0);

    a_r1_off_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == VS_OFF) |=> !victim_valid);
endmodule

// File: tb/vws_victim_sel_test.sv
module vws_victim_sel_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cache_en = 1'b0;
    logic       policy_rand = 1'b0;
    logic       fill_req = 1'b0;
    logic [3:0] lock_mask = 4'h0;
    logic       victim_valid;
    logic [1:0] victim_way;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vws_victim_sel uut (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .policy_rand(policy_rand),
        .fill_req(fill_req), .lock_mask(lock_mask),
        .victim_valid(victim_valid), .victim_way(victim_way)
    );

    // reference model built from the requirements (0 off, 1 rotate, 2 random)
    int          m_st, m_ptr, m_nxt, m_pick;
    logic [15:0] m_rnd;
    logic        exp_valid;
    int          exp_way;
    string       exp_tag;
    logic [3:0]  exp_mask;
    bit          m_fresh;

    function automatic int lowest_ok(input logic [3:0] a);
        for (int i = 0; i < 4; i++) if (a[i]) return i;
        return 0;
    endfunction

    function automatic int first_from(input logic [3:0] a, input int s);
        for (int k = 0; k < 4; k++) if (a[(s + k) % 4]) return (s + k) % 4;
        return 0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_ptr = 0; m_rnd = 16'hACE1;
            exp_valid = 1'b0; exp_way = 0; exp_tag = "R1"; m_fresh = 1'b0;
            exp_mask = 4'h0;
        end else begin
            m_nxt = !cache_en ? 0 : (policy_rand ? 2 : 1);
            exp_mask = lock_mask;
            if (fill_req && cache_en && m_st != 0) begin
                if (lock_mask == 4'hF) begin
                    m_pick = 0; exp_tag = "R10";
                end else if (m_st == 1) begin
                    m_pick = first_from(~lock_mask, m_ptr);
                    exp_tag = m_fresh ? "R6" : "R5";
                end else if (!lock_mask[m_rnd[1:0]]) begin
                    m_pick = int'(m_rnd[1:0]); exp_tag = "R7";
                end else begin
                    m_pick = lowest_ok(~lock_mask); exp_tag = "R8";
                end
                if (m_nxt != m_st && m_nxt != 0) exp_tag = "R4";
                exp_valid = 1'b1; exp_way = m_pick;
                if (m_st == 1) begin m_ptr = (m_pick + 1) % 4; m_fresh = 1'b0; end
            end else begin
                exp_valid = 1'b0;
                exp_tag = cache_en ? "R3" : "R2";
            end
            if (m_nxt != m_st && m_nxt != 0) begin
                m_ptr = lowest_ok(~lock_mask); m_fresh = 1'b1;
            end
            m_st = m_nxt;
            m_rnd = {m_rnd[14:0], m_rnd[15] ^ m_rnd[13] ^ m_rnd[12] ^ m_rnd[10]};
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (victim_valid !== exp_valid) begin
                failures++;
                $display("FAIL %s valid actual=%0b expected=%0b", exp_tag, victim_valid, exp_valid);
            end
            if (exp_valid) begin
                checks++;
                if (int'(victim_way) != exp_way) begin
                    failures++;
                    $display("FAIL %s way actual=%0d expected=%0d", exp_tag, victim_way, exp_way);
                end
                if (exp_mask != 4'hF) begin
                    checks++;
                    if (exp_mask[victim_way]) begin
                        failures++;
                        $display("FAIL R9 excluded way actual=%0d expected=not in mask %b",
                                 victim_way, exp_mask);
                    end
                end
            end
        end
    end

    task automatic step(input logic en, input logic pol, input logic req, input logic [3:0] m);
        @(negedge clk);
        cache_en = en; policy_rand = pol; fill_req = req; lock_mask = m;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;   // R1 reset state
        if (victim_valid !== 1'b0 || victim_way !== 2'd0) begin
            failures++;
            $display("FAIL R1 reset actual=%0b/%0d expected=0/0", victim_valid, victim_way);
        end
        rst_n = 1'b1;
        // R2: requests while disabled
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b1, 4'h0);
        // R2: request on the enabling edge is not granted
        step(1'b1, 1'b0, 1'b1, 4'h0);
        // R5/R9/R10: rotation over every mask, with gaps
        for (int m = 0; m < 16; m++)
            for (int k = 0; k < 6; k++) step(1'b1, 1'b0, k != 2, 4'(m));
        // R4: request on the switching edge uses the old policy
        step(1'b1, 1'b1, 1'b1, 4'h0);
        // R7/R8/R10: random over every mask
        for (int m = 0; m < 16; m++)
            for (int k = 0; k < 20; k++) step(1'b1, 1'b1, (k % 3) != 1, 4'(m));
        // R6: back to rotation, first grant is lowest allowed
        step(1'b1, 1'b0, 1'b0, 4'b0101);
        for (int k = 0; k < 5; k++) step(1'b1, 1'b0, 1'b1, 4'b0101);
        // R2 then R6 after re-enable
        for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 1'b1, 4'h0);
        step(1'b1, 1'b0, 1'b0, 4'b0011);
        for (int k = 0; k < 6; k++) step(1'b1, 1'b0, 1'b1, 4'b0011);
        step(1'b1, 1'b0, 1'b0, 4'h0);
        step(1'b1, 1'b0, 1'b0, 4'h0);
        @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end
endmodule